// File: doc/BRIEF.md
# Programmable Eight-State Sequencer

This block is a Mealy state machine with eight states whose behaviour is loaded at run time instead of being fixed in logic. The current state is a 3-bit index into a table of eight 22-bit state words. Each cycle the indexed word selects one of sixteen decision inputs and feeds it to a small truth table. When the truth table returns 1, the machine jumps to the target state in the word and drives that word's jump outputs. When it returns 0, it drives the word's steady outputs. A per-state step flag lets a run of states be tested in turn: the machine walks forward through them and then returns to the first one, until one of them fires.

A 15-bit up/clear counter is included. Two of the five outputs control it. Decision input 3 reports when the counter matches a compare value, so a loaded program can wait for a time interval. The table and the compare value are written through a serial chain while the machine is disabled. When the machine is enabled it starts from state 0.

Top module: `prog_fsm_core`

## Requirements
- R1: While `rst_n` is low and after its release, `fsm_out` is 0, the state is 0, the counter is 0, and every table bit and compare bit is 0. With that all-zero table enabled, `fsm_out` stays 0.
- R2: A state word has this layout: [21:18] input select, [17:14] truth table, [13:9] jump outputs, [8:4] steady outputs, [3:1] jump target, [0] step flag. The decision is truth-table bit {selected input, 0}, that is bit 0 when the input is 0 and bit 2 when it is 1. Select values 0..2 read `pin_in[0..2]`, value 3 reads the counter match, and values 4..15 read 0.
- R3: When the machine is enabled and the decision is 1, the next clock loads `fsm_out` with the jump outputs and moves the state to the jump target.
- R4: When the machine is enabled, the decision is 0, the step flag is clear and no loop is active, the next clock loads `fsm_out` with the steady outputs and the state stays the same.
- R5: When the decision is 0 and the step flag is set, the steady outputs are driven and the state advances by one (state 7 wraps to 0). The first state of such a run is recorded as the loop start.
- R6: When the decision is 0, the step flag is clear and a loop start is recorded, the steady outputs are driven and the state returns to the loop start. The record is kept.
- R7: Taking any jump discards the recorded loop start.
- R8: When `enable` is low at a clock, the next state is 0, `fsm_out` becomes 0, the loop record is discarded and the counter is cleared.
- R9: While `enable` is low, each clock with `cfg_shift` high shifts `cfg_data` into a 191-bit chain. The sequence is state word 7 first down to word 0, each MSB first, followed by the 15-bit compare value MSB first. While `enable` is high, `cfg_shift` has no effect.
- R10: The counter clears on a clock where `fsm_out[3]` is 1. Otherwise it adds one (wrapping at 15 bits) on a clock where `fsm_out[4]` is 1, and holds in all other cases. Clear wins over increment.
- R11: Decision input 3 is 1 exactly while the counter value equals the loaded compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run when high; hold at state 0 and permit loading when low |
| cfg_shift | input | 1 | Shift strobe for the configuration chain |
| cfg_data | input | 1 | Serial configuration bit |
| pin_in | input | 3 | External decision inputs 0..2 |
| fsm_out | output | 5 | Registered outputs; bit 4 increments the counter, bit 3 clears it |

## Verification
On every cycle the assertions check the following. A fired decision lands on the word's target with its jump outputs. An unfired one drives the steady outputs. A set step flag advances the index. A disabled machine returns home with silent outputs. The table never moves while running. The counter clears, increments or holds exactly as its two controls say. Other behaviour only shows over whole sequences, so the bench scenarios cover it. These include the return to the recorded loop start and the loss of that record after a jump. They also include the 7-to-0 wrap, unused selects reading 0, clear taking priority during a counter-timed wait, and the loaded table staying intact after shifting was attempted while running.

// File: rtl/pfsm_pkg.sv
package pfsm_pkg;

    localparam int N_STATES = 8;
    localparam int IDX_W    = $clog2(N_STATES);
    localparam int N_OUT    = 5;
    localparam int SEL_W    = 4;
    localparam int N_IN     = 1 << SEL_W;
    localparam int LUT_W    = 4;
    localparam int WORD_W   = SEL_W + LUT_W + 2 * N_OUT + IDX_W + 1;
    localparam int OUT_INC  = 4;
    localparam int OUT_CLR  = 3;

    // One table entry, most significant field first.
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [LUT_W-1:0] lut;
        logic [N_OUT-1:0] jmp_out;
        logic [N_OUT-1:0] hold_out;
        logic [IDX_W-1:0] target;
        logic             step;
    } sword_t;

    // Registered engine state.
    typedef struct packed {
        logic [IDX_W-1:0] cur;
        logic             lp_vld;
        logic [IDX_W-1:0] lp_start;
        logic [N_OUT-1:0] outs;
    } eng_t;

endpackage

// File: rtl/pfsm_cfg_chain.sv
module pfsm_cfg_chain
    import pfsm_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_i,
    input  logic                       data_i,
    output sword_t [N_STATES-1:0]      table_o,
    output logic   [CNT_W-1:0]         cmp_o
);

    localparam int CHAIN_W = N_STATES * WORD_W + CNT_W;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (shift_i) begin
            chain_d = {chain_q[CHAIN_W-2:0], data_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    // The first bit shifted in ends at the top: entry 7 highest, compare lowest.
    genvar ge;
    generate
        for (ge = 0; ge < N_STATES; ge++) begin : g_entry
            assign table_o[ge] = chain_q[CNT_W + ge * WORD_W +: WORD_W];
        end
    endgenerate

    assign cmp_o = chain_q[CNT_W-1:0];

endmodule

// File: rtl/pfsm_counter.sv
module pfsm_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             inc_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!enable || clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o   = cnt_q;
    assign match_o = (cnt_q == cmp_i);

endmodule

// File: rtl/pfsm_engine.sv
module pfsm_engine
    import pfsm_pkg::*;
#(
    parameter int N_PINS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  sword_t [N_STATES-1:0]  table_i,
    input  logic   [N_PINS-1:0]    pin_i,
    input  logic                   cmp_hit_i,
    output logic   [N_OUT-1:0]     outs_o,
    output logic   [IDX_W-1:0]     state_o,
    output sword_t                 word_o,
    output logic                   hit_o
);

    logic [N_IN-1:0] in_vec;

    // Pins first, then the counter match, then constant zeros.
    genvar gi;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_in
            if (gi < N_PINS) begin : g_pin
                assign in_vec[gi] = pin_i[gi];
            end else if (gi == N_PINS) begin : g_cmp
                assign in_vec[gi] = cmp_hit_i;
            end else begin : g_zero
                assign in_vec[gi] = 1'b0;
            end
        end
    endgenerate

    eng_t   st_d, st_q;
    sword_t word;
    logic   sel_bit;
    logic   hit;

    always_comb begin
        word    = table_i[st_q.cur];
        sel_bit = in_vec[word.sel];
        hit     = word.lut[{sel_bit, 1'b0}];
        st_d    = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (hit) begin
            st_d.cur    = word.target;
            st_d.lp_vld = 1'b0;
            st_d.outs   = word.jmp_out;
        end else begin
            st_d.outs = word.hold_out;
            if (word.step) begin
                if (!st_q.lp_vld) begin
                    st_d.lp_vld   = 1'b1;
                    st_d.lp_start = st_q.cur;
                end
                st_d.cur = st_q.cur + IDX_W'(1);
            end else if (st_q.lp_vld) begin
                st_d.cur = st_q.lp_start;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign outs_o  = st_q.outs;
    assign state_o = st_q.cur;
    assign word_o  = word;
    assign hit_o   = hit;

endmodule

// File: rtl/prog_fsm_core.sv
module prog_fsm_core
    import pfsm_pkg::*;
#(
    parameter int N_PINS = 3,
    parameter int CNT_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cfg_shift,
    input  logic              cfg_data,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_OUT-1:0]  fsm_out
);

    sword_t [N_STATES-1:0] cfg_table;
    sword_t                cur_word;
    logic   [CNT_W-1:0]    cmp_val;
    logic   [CNT_W-1:0]    cnt_val;
    logic   [IDX_W-1:0]    cur_state;
    logic                  cnt_match;
    logic                  lut_hit;
    logic                  load_en;

    assign load_en = cfg_shift & ~enable;

    pfsm_cfg_chain #(.CNT_W(CNT_W)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (load_en),
        .data_i  (cfg_data),
        .table_o (cfg_table),
        .cmp_o   (cmp_val)
    );

    pfsm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .inc_i   (fsm_out[OUT_INC]),
        .clr_i   (fsm_out[OUT_CLR]),
        .cmp_i   (cmp_val),
        .cnt_o   (cnt_val),
        .match_o (cnt_match)
    );

    pfsm_engine #(.N_PINS(N_PINS)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .table_i   (cfg_table),
        .pin_i     (pin_in),
        .cmp_hit_i (cnt_match),
        .outs_o    (fsm_out),
        .state_o   (cur_state),
        .word_o    (cur_word),
        .hit_o     (lut_hit)
    );

endmodule

// File: rtl/pfsm_chk.sv
module pfsm_chk
    import pfsm_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic [N_OUT-1:0]      fsm_out,
    input logic [IDX_W-1:0]      cur_state,
    input sword_t                cur_word,
    input logic                  lut_hit,
    input logic [CNT_W-1:0]      cnt_val,
    input sword_t [N_STATES-1:0] cfg_table
);

    AST_OFF_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cur_state == '0) && (fsm_out == '0)); // R8

    AST_JUMP_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && lut_hit) |=> cur_state == $past(cur_word.target)); // R3

    AST_JUMP_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && lut_hit) |=> fsm_out == $past(cur_word.jmp_out)); // R3

    AST_HOLD_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !lut_hit) |=> fsm_out == $past(cur_word.hold_out)); // R4

    AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !lut_hit && cur_word.step)
        |=> cur_state == IDX_W'($past(cur_state) + IDX_W'(1))); // R5

    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(cfg_table)); // R9

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || fsm_out[OUT_CLR]) |=> cnt_val == '0); // R10

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !fsm_out[OUT_CLR] && fsm_out[OUT_INC])
        |=> cnt_val == CNT_W'($past(cnt_val) + CNT_W'(1))); // R10

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !fsm_out[OUT_CLR] && !fsm_out[OUT_INC]) |=> $stable(cnt_val)); // R10

endmodule

bind prog_fsm_core pfsm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .fsm_out   (fsm_out),
    .cur_state (cur_state),
    .cur_word  (cur_word),
    .lut_hit   (lut_hit),
    .cnt_val   (cnt_val),
    .cfg_table (cfg_table)
);

// File: tb/tb_prog_fsm_core.sv
module tb_prog_fsm_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_shift = 1'b0;
    logic       cfg_data = 1'b0;
    logic [2:0] pin_in = 3'b000;
    logic [4:0] fsm_out;

    prog_fsm_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cfg_shift (cfg_shift),
        .cfg_data  (cfg_data),
        .pin_in    (pin_in),
        .fsm_out   (fsm_out)
    );

    always #4 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    cmp_on = 1'b0;

    // Behavioural reference model
    int m_tbl[8];
    int m_cmp = 0;
    int m_st = 0;
    int m_ls = 0;
    int m_out = 0;
    int m_cnt = 0;
    bit m_lv = 1'b0;

    initial begin
        for (int i = 0; i < 8; i++) m_tbl[i] = 0;
    end

    always @(posedge clk) begin
        int w;
        int sel;
        int iv;
        int in3;
        if (!rst_n) begin
            m_st = 0; m_ls = 0; m_out = 0; m_cnt = 0; m_lv = 1'b0;
        end else begin
            in3 = (m_cnt == m_cmp) ? 1 : 0;
            if (!enable || ((m_out >> 3) & 1) == 1) m_cnt = 0;
            else if (((m_out >> 4) & 1) == 1) m_cnt = (m_cnt + 1) % 32768;
            if (!enable) begin
                m_st = 0; m_lv = 1'b0; m_out = 0;
            end else begin
                w   = m_tbl[m_st];
                sel = (w >> 18) & 15;
                if (sel < 3) iv = int'(pin_in[sel]);
                else if (sel == 3) iv = in3;
                else iv = 0;
                if (((w >> (14 + 2 * iv)) & 1) == 1) begin
                    m_out = (w >> 9) & 31;
                    m_st  = (w >> 1) & 7;
                    m_lv  = 1'b0;
                end else begin
                    m_out = (w >> 4) & 31;
                    if ((w & 1) == 1) begin
                        if (!m_lv) begin
                            m_lv = 1'b1;
                            m_ls = m_st;
                        end
                        m_st = (m_st + 1) % 8;
                    end else if (m_lv) begin
                        m_st = m_ls;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            n_vec++;
            if ($isunknown(fsm_out) || int'(fsm_out) != m_out) begin
                n_bad++;
                $display("FAIL %s model compare: fsm_out=%02h expected=%02h at %0t",
                         tag, fsm_out, m_out, $time);
            end
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input int exp, input string t);
        n_vec++;
        if ($isunknown(fsm_out) || int'(fsm_out) != exp) begin
            n_bad++;
            $display("FAIL %s directed: fsm_out=%02h expected=%02h at %0t",
                     t, fsm_out, exp, $time);
        end
    endtask

    function automatic int mkw(input int sel, input int lut, input int jo,
                               input int so, input int tgt, input int inc);
        return (sel << 18) | (lut << 14) | (jo << 9) | (so << 4) | (tgt << 1) | inc;
    endfunction

    task automatic load_table(input int t[8], input int c);
        enable = 1'b0;
        step();
        for (int e = 7; e >= 0; e--) begin
            for (int b = 21; b >= 0; b--) begin
                cfg_shift = 1'b1;
                cfg_data  = ((t[e] >> b) & 1) == 1;
                step();
            end
        end
        for (int b = 14; b >= 0; b--) begin
            cfg_shift = 1'b1;
            cfg_data  = ((c >> b) & 1) == 1;
            step();
        end
        cfg_shift = 1'b0;
        cfg_data  = 1'b0;
        for (int i = 0; i < 8; i++) m_tbl[i] = t[i];
        m_cmp = c;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    int t1[8];
    int t2[8];

    initial begin
        t1[0] = mkw(0, 'hE, 'h01, 'h02, 1, 0);
        t1[1] = mkw(1, 'hE, 'h03, 'h04, 5, 1);
        t1[2] = mkw(2, 'hE, 'h05, 'h06, 6, 1);
        t1[3] = mkw(5, 'hE, 'h1F, 'h07, 4, 0);
        t1[4] = mkw(0, 'h0, 'h00, 'h09, 0, 1);
        t1[5] = mkw(0, 'hF, 'h18, 'h0B, 0, 0);
        t1[6] = mkw(0, 'h1, 'h1C, 'h0D, 7, 0);
        t1[7] = mkw(3, 'hE, 'h08, 'h10, 0, 0);
        for (int i = 0; i < 8; i++) t2[i] = 0;
        t2[0] = mkw(0, 'h1, 'h11, 'h10, 6, 0);
        t2[6] = mkw(1, 'hE, 'h1E, 'h16, 2, 1);
        t2[7] = mkw(1, 'h0, 'h00, 'h17, 0, 1);
        t2[2] = mkw(0, 'hF, 'h12, 'h00, 0, 0);

        // R1: reset state and the all-zero table
        step(3);
        chk(0, "R1");
        rst_n = 1'b1;
        step();
        chk(0, "R1");
        cmp_on = 1'b1;
        enable = 1'b1;
        step(3);
        chk(0, "R1");

        // R9: serial load of the first program
        tag = "R9";
        load_table(t1, 5);

        // Directed walk through the first program
        tag = "R3";
        enable = 1'b1;
        step();      chk('h02, "R4");
        pin_in = 3'b001;
        step();      chk('h01, "R3");
        pin_in = 3'b000;
        step();      chk('h04, "R5");
        step();      chk('h06, "R5");
        step();      chk('h07, "R2");
        step();      chk('h04, "R6");
        pin_in = 3'b100;
        step();      chk('h05, "R3");
        pin_in = 3'b001;
        step();      chk('h0D, "R7");
        step();      chk('h0D, "R7");
        pin_in = 3'b000;
        tag = "R10";
        step();      chk('h1C, "R10");
        for (int k = 0; k < 6; k++) begin
            step();  chk('h10, "R10");
        end
        step();      chk('h08, "R11");
        step();      chk('h02, "R4");

        // R8: disable returns home
        tag = "R8";
        enable = 1'b0;
        step();      chk(0, "R8");
        enable = 1'b1;
        pin_in = 3'b001;
        step();      chk('h01, "R8");

        // Second program: step loop with wrap
        tag = "R9";
        pin_in = 3'b000;
        load_table(t2, 'h7FFF);
        tag = "R5";
        enable = 1'b1;
        step();      chk('h11, "R3");
        pin_in = 3'b001;
        step();      chk('h16, "R5");
        step();      chk('h17, "R5");
        step();      chk('h10, "R6");
        step();      chk('h16, "R6");
        pin_in = 3'b011;
        step();      chk('h17, "R5");
        step();      chk('h10, "R6");
        step();      chk('h1E, "R3");
        step();      chk('h12, "R7");
        step();      chk('h10, "R7");
        step();      chk('h10, "R7");

        // R9: shifting while running is ignored
        tag = "R9";
        cfg_shift = 1'b1;
        cfg_data  = 1'b1;
        step(30);
        chk('h10, "R9");
        cfg_shift = 1'b0;
        cfg_data  = 1'b0;
        enable = 1'b0;
        pin_in = 3'b000;
        step();      chk(0, "R9");
        enable = 1'b1;
        step();      chk('h11, "R9");

        // Random stimulus against the model on the first program
        tag = "R2";
        load_table(t1, 5);
        tag = "R3";
        for (int i = 0; i < 4000; i++) begin
            pin_in = 3'($urandom_range(0, 7));
            enable = ($urandom_range(0, 59) != 0);
            step();
        end

        finish_run();
    end

endmodule